// File: doc/BRIEF.md
# Block-Write I2C Configuration Slave

This block is an I2C target that holds a 21-byte configuration register file for a clock-generation subsystem. It has no register pointer: every write transfer starts filling the file at byte 0 and moves upward one byte at a time. Every read transfer first returns a length byte and then the bytes from index 0 upward. The host writes the device address, then a command byte and a count byte, both of which are acknowledged and thrown away, then as many data bytes as it wants. It may end the transfer with a stop after any whole byte.

SCL and SDA are oversampled by the system clock through two-flop synchronizers. The block finds start and stop conditions, matches the address, drives acknowledge and read data as an open-drain pull-down enable, and commits the register file. Two byte pairs (divider bytes 11/12 and spread bytes 13/14) take effect only as whole pairs. Byte 7 holds a fixed identifier, and byte 8 sets how far a read goes. The live contents are always visible on a flat output bus for the logic around the block.

Top module: `cfg_i2c_slave`

## Requirements
- R1: The block acknowledges the address byte D2h (write) and D3h (read). For any other address byte it does not acknowledge, and it leaves SDA undriven until the next start.
- R2: In a write, the two bytes after the address (command and count) are acknowledged, and their values change no register.
- R3: From the third byte after the address on, byte j of the transfer is written to register j-3, beginning at register 0, and each byte is acknowledged. A stop after any complete byte leaves all registers past the last one written unchanged.
- R4: A read first returns the value of register 8. It then returns register k for k = 0, 1, ... while k is no greater than that value and k ≤ 20. Past that point it returns FFh. A host NACK ends the transfer.
- R5: Register 8 resets to 08h. A write of 00h to it stores 01h, and the register never holds 00h.
- R6: Register 7 always reads as the identifier A5h. Writes to it are acknowledged and dropped.
- R7: Registers 11 and 12 both take their new values in the same clock cycle, when byte 12 is received. If byte 11 arrives but the transfer ends (stop or repeated start) before byte 12 arrives, neither register changes.
- R8: Registers 13 and 14 follow the same paired rule, committing when byte 14 is received.
- R9: Registers 19 and 20 are plain storage. Writing them changes no other register.
- R10: After reset, register 7 = A5h, register 8 = 08h, register 9 = 10h, all other registers = 00h, and SDA is released.
- R11: The SDA drive changes only while SCL is low. Start and stop are recognised as SDA edges while SCL is high. A repeated start begins a new transfer at once.
- R12: Data bytes after register 20 are acknowledged and dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line as seen at the pad |
| sda_i | input | 1 | I2C data line as seen at the pad |
| sda_oe_o | output | 1 | High pulls SDA low (open-drain enable) |
| regs_o | output | 168 | Live register file, register k at bits [8k+7:8k] |

## Verification
Write transfers are tried in several forms:
- Stopped after a few bytes, which separates correct sequential placement from writes that spill past the stop.
- Ended between the two halves of each pair, which shows whether a lone first byte leaks into the live registers.
- Running past register 20, which separates dropped overflow from wraparound.

Reads are tried with small, full and random length settings, which tells a correct length limit from an off-by-one and shows the FFh fill. A repeated start inside a half-finished pair, a foreign address, a zero written to the length register and a write to the identifier cover the remaining corner cases. Random data and random transfer lengths run against a bench model of the pairing rules.

// File: rtl/cfg_pkg.sv
`timescale 1ns/1ps
package cfg_pkg;
  localparam int unsigned REG_BYTES  = 21;
  localparam int unsigned IDX_ID     = 7;
  localparam int unsigned IDX_RDLEN  = 8;
  localparam int unsigned IDX_WDOG   = 9;
  localparam int unsigned IDX_DIV_LO = 11;
  localparam int unsigned IDX_SS_LO  = 13;
  localparam int unsigned NUM_PAIRS  = 2;
  localparam logic [6:0]  DEV_ADDR7  = 7'h69;
  localparam logic [7:0]  ID_BYTE    = 8'hA5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ACK, ST_WDATA, ST_RDATA, ST_HACK
  } link_st_e;

  function automatic int pair_lo(int p);
    return (p == 0) ? int'(IDX_DIV_LO) : int'(IDX_SS_LO);
  endfunction

  // -1 when byte k is not part of a committed pair
  function automatic int pair_slot(int k);
    for (int p = 0; p < int'(NUM_PAIRS); p++)
      if (k == pair_lo(p) || k == pair_lo(p) + 1) return p;
    return -1;
  endfunction

  function automatic logic [7:0] rst_byte(int k, logic [7:0] id);
    if (k == int'(IDX_ID))    return id;
    if (k == int'(IDX_RDLEN)) return 8'h08;
    if (k == int'(IDX_WDOG))  return 8'h10;
    return 8'h00;
  endfunction
endpackage

// File: rtl/i2c_front.sv
`timescale 1ns/1ps
module i2c_front #(
  parameter int unsigned SYNC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC:0] scl_p, sda_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[SYNC-1:0], scl_i};
      sda_p <= {sda_p[SYNC-1:0], sda_i};
    end
  end

  logic scl_now, scl_old, sda_now, sda_old;
  assign scl_now = scl_p[SYNC-1];
  assign scl_old = scl_p[SYNC];
  assign sda_now = sda_p[SYNC-1];
  assign sda_old = sda_p[SYNC];

  assign scl_o      = scl_now;
  assign sda_o      = sda_now;
  assign scl_rise_o = scl_now & ~scl_old;
  assign scl_fall_o = ~scl_now & scl_old;
  assign start_o    = scl_now & scl_old & sda_old & ~sda_now;
  assign stop_o     = scl_now & scl_old & ~sda_old & sda_now;

  assert_events_exclusive_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({start_o, stop_o, scl_rise_o, scl_fall_o}));
endmodule

// File: rtl/i2c_link.sv
`timescale 1ns/1ps
module i2c_link
  import cfg_pkg::*;
#(
  parameter logic [6:0] DEV  = DEV_ADDR7,
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             start_i,
  input  logic             stop_i,
  output logic             sda_oe_o,
  output logic             wr_stb_o,
  output logic [CNT_W-1:0] wr_idx_o,
  output logic [7:0]       wr_data_o,
  output logic [CNT_W-1:0] rd_pos_o,
  input  logic [7:0]       rd_byte_i
);
  link_st_e         st_q;
  logic [3:0]       bit_cnt_q;
  logic [7:0]       sh_q;
  logic             rnw_q, oe_q, hack_q;
  logic [CNT_W-1:0] wcnt_q, rpos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      bit_cnt_q <= '0;
      sh_q      <= '0;
      rnw_q     <= 1'b0;
      oe_q      <= 1'b0;
      hack_q    <= 1'b0;
      wcnt_q    <= '0;
      rpos_q    <= '0;
      wr_stb_o  <= 1'b0;
      wr_idx_o  <= '0;
      wr_data_o <= '0;
    end else begin
      wr_stb_o <= 1'b0;
      if (start_i) begin
        st_q      <= ST_ADDR;
        bit_cnt_q <= '0;
        oe_q      <= 1'b0;
        wcnt_q    <= '0;
        rpos_q    <= '0;
      end else if (stop_i) begin
        st_q <= ST_IDLE;
        oe_q <= 1'b0;
      end else begin
        case (st_q)
          ST_ADDR: begin
            if (scl_rise_i) begin
              sh_q      <= {sh_q[6:0], sda_i};
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end else if (scl_fall_i && bit_cnt_q == 4'd8) begin
              if (sh_q[7:1] == DEV) begin
                st_q  <= ST_ACK;
                oe_q  <= 1'b1;
                rnw_q <= sh_q[0];
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall_i) begin
              bit_cnt_q <= '0;
              if (rnw_q) begin
                st_q <= ST_RDATA;
                sh_q <= rd_byte_i;
                oe_q <= ~rd_byte_i[7];
                if (rpos_q != '1) rpos_q <= rpos_q + 1'b1;
              end else begin
                st_q <= ST_WDATA;
                oe_q <= 1'b0;
              end
            end
          end
          ST_WDATA: begin
            if (scl_rise_i) begin
              sh_q      <= {sh_q[6:0], sda_i};
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end else if (scl_fall_i && bit_cnt_q == 4'd8) begin
              st_q      <= ST_ACK;
              oe_q      <= 1'b1;
              wr_stb_o  <= (wcnt_q >= CNT_W'(2));
              wr_idx_o  <= wcnt_q - CNT_W'(2);
              wr_data_o <= sh_q;
              if (wcnt_q != '1) wcnt_q <= wcnt_q + 1'b1;
            end
          end
          ST_RDATA: begin
            if (scl_rise_i) begin
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end else if (scl_fall_i) begin
              if (bit_cnt_q == 4'd8) begin
                st_q <= ST_HACK;
                oe_q <= 1'b0;
              end else begin
                sh_q <= {sh_q[6:0], 1'b1};
                oe_q <= ~sh_q[6];
              end
            end
          end
          ST_HACK: begin
            if (scl_rise_i) begin
              hack_q <= ~sda_i;
            end else if (scl_fall_i) begin
              if (hack_q) begin
                st_q      <= ST_RDATA;
                bit_cnt_q <= '0;
                sh_q      <= rd_byte_i;
                oe_q      <= ~rd_byte_i[7];
                if (rpos_q != '1) rpos_q <= rpos_q + 1'b1;
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o = oe_q;
  assign rd_pos_o = rpos_q;

  assert_oe_quiet_scl_high_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_i && $past(scl_i)) |-> $stable(oe_q));

  assert_no_ack_foreign_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ADDR && scl_fall_i && !start_i && !stop_i && bit_cnt_q == 4'd8 && sh_q[7:1] != DEV)
    |=> !sda_oe_o);
endmodule

// File: rtl/cfg_regfile.sv
`timescale 1ns/1ps
module cfg_regfile
  import cfg_pkg::*;
#(
  parameter int unsigned NUM_BYTES = REG_BYTES,
  parameter int unsigned CNT_W     = 6,
  parameter logic [7:0]  ID_VALUE  = ID_BYTE
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_stb_i,
  input  logic [CNT_W-1:0]       wr_idx_i,
  input  logic [7:0]             wr_data_i,
  input  logic                   txn_edge_i,
  input  logic [CNT_W-1:0]       rd_pos_i,
  output logic [7:0]             rd_byte_o,
  output logic [NUM_BYTES*8-1:0] regs_o
);
  logic [7:0] live [NUM_BYTES];
  logic [7:0] shadow [NUM_PAIRS];
  logic       commit [NUM_PAIRS];

  for (genvar gp = 0; gp < int'(NUM_PAIRS); gp++) begin : g_pair
    localparam int LO = pair_lo(gp);
    logic       pend_q;
    logic [7:0] sh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_q <= 1'b0;
        sh_q   <= '0;
      end else if (txn_edge_i) begin
        pend_q <= 1'b0;
      end else if (wr_stb_i && wr_idx_i == CNT_W'(LO)) begin
        sh_q   <= wr_data_i;
        pend_q <= 1'b1;
      end else if (wr_stb_i && wr_idx_i == CNT_W'(LO + 1)) begin
        pend_q <= 1'b0;
      end
    end
    assign shadow[gp] = sh_q;
    assign commit[gp] = wr_stb_i && wr_idx_i == CNT_W'(LO + 1) && pend_q;
  end

  for (genvar gi = 0; gi < int'(NUM_BYTES); gi++) begin : g_byte
    if (gi == int'(IDX_ID)) begin : g_id
      assign live[gi] = ID_VALUE;
    end else begin : g_flop
      logic       we;
      logic [7:0] nd, q;
      if (pair_slot(gi) >= 0) begin : g_paired
        localparam int PS = pair_slot(gi);
        assign we = commit[PS];
        assign nd = (gi == pair_lo(PS)) ? shadow[PS] : wr_data_i;
      end else if (gi == int'(IDX_RDLEN)) begin : g_len
        assign we = wr_stb_i && wr_idx_i == CNT_W'(gi);
        assign nd = (wr_data_i == 8'h00) ? 8'h01 : wr_data_i;
      end else begin : g_plain
        assign we = wr_stb_i && wr_idx_i == CNT_W'(gi);
        assign nd = wr_data_i;
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  q <= rst_byte(gi, ID_VALUE);
        else if (we)  q <= nd;
      end
      assign live[gi] = q;
    end
    assign regs_o[gi*8 +: 8] = live[gi];
  end

  always_comb begin
    rd_byte_o = 8'hFF;
    if (rd_pos_i == '0) begin
      rd_byte_o = live[IDX_RDLEN];
    end else begin
      for (int k = 0; k < int'(NUM_BYTES); k++)
        if (rd_pos_i == CNT_W'(k + 1) && 8'(k) <= live[IDX_RDLEN]) rd_byte_o = live[k];
    end
  end

  assert_rdlen_nonzero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live[IDX_RDLEN] != 8'h00);

  assert_div_pair_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(live[IDX_DIV_LO]) || !$stable(live[IDX_DIV_LO+1]))
    |-> $past(wr_stb_i && wr_idx_i == CNT_W'(IDX_DIV_LO + 1)));

  assert_ss_pair_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(live[IDX_SS_LO]) || !$stable(live[IDX_SS_LO+1]))
    |-> $past(wr_stb_i && wr_idx_i == CNT_W'(IDX_SS_LO + 1)));
endmodule

// File: rtl/cfg_i2c_slave.sv
`timescale 1ns/1ps
module cfg_i2c_slave
  import cfg_pkg::*;
#(
  parameter int unsigned NUM_BYTES = REG_BYTES,
  parameter logic [6:0]  DEV       = DEV_ADDR7,
  parameter logic [7:0]  ID_VALUE  = ID_BYTE
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   scl_i,
  input  logic                   sda_i,
  output logic                   sda_oe_o,
  output logic [NUM_BYTES*8-1:0] regs_o
);
  localparam int unsigned CNT_W = $clog2(NUM_BYTES + 3) + 1;

  logic scl_s, sda_s, scl_rise, scl_fall, start, stop;
  logic             wr_stb;
  logic [CNT_W-1:0] wr_idx, rd_pos;
  logic [7:0]       wr_data, rd_byte;

  i2c_front #(.SYNC(2)) u_front (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start), .stop_o(stop)
  );

  i2c_link #(.DEV(DEV), .CNT_W(CNT_W)) u_link (
    .clk_i, .rst_ni,
    .scl_i(scl_s), .sda_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start), .stop_i(stop),
    .sda_oe_o,
    .wr_stb_o(wr_stb), .wr_idx_o(wr_idx), .wr_data_o(wr_data),
    .rd_pos_o(rd_pos), .rd_byte_i(rd_byte)
  );

  cfg_regfile #(.NUM_BYTES(NUM_BYTES), .CNT_W(CNT_W), .ID_VALUE(ID_VALUE)) u_regs (
    .clk_i, .rst_ni,
    .wr_stb_i(wr_stb), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .txn_edge_i(start | stop),
    .rd_pos_i(rd_pos), .rd_byte_o(rd_byte),
    .regs_o
  );
endmodule

// File: tb/tb_cfg_i2c_slave.sv
`timescale 1ns/1ps
module tb_cfg_i2c_slave;
  localparam int NB   = 21;
  localparam int HALF = 16;
  localparam int Q    = 6;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe;
  logic [NB*8-1:0] regs;
  logic sda_line;

  always #2.5 clk = ~clk;
  assign sda_line = m_sda & ~sda_oe;

  cfg_i2c_slave dut (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .regs_o(regs)
  );

  int vectors = 0, miscompares = 0, viol = 0;
  logic [7:0] exp_r [0:NB-1];
  logic [7:0] wbuf [0:23];

  logic scl_prev = 1'b1, oe_prev = 1'b0;
  always @(posedge clk) begin
    if (rst_ni && m_scl && scl_prev && sda_oe != oe_prev) viol++;
    scl_prev <= m_scl;
    oe_prev  <= sda_oe;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    vectors++;
    if (act !== expv) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; w(Q); m_scl = 1'b1; w(HALF);
    m_sda = 1'b0; w(HALF); m_scl = 1'b0; w(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; w(HALF - Q); m_scl = 1'b1; w(HALF); m_sda = 1'b1; w(HALF);
  endtask

  task automatic bus_bit(input logic b, output logic r);
    m_sda = b; w(HALF - Q); m_scl = 1'b1; w(HALF / 2);
    r = sda_line; w(HALF / 2); m_scl = 1'b0; w(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bus_bit(d[i], r);
    bus_bit(1'b1, r);
    ack = ~r;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, r);
      d[i] = r;
    end
    bus_bit(~give_ack, r);
  endtask

  task automatic model_apply(input int n);
    logic p0, p1;
    logic [7:0] s0, s1, d;
    p0 = 1'b0; p1 = 1'b0; s0 = '0; s1 = '0;
    for (int k = 0; k < n; k++) begin
      d = wbuf[k];
      case (k)
        7: ;
        8: exp_r[8] = (d == 8'h00) ? 8'h01 : d;
        11: begin s0 = d; p0 = 1'b1; end
        12: begin if (p0) begin exp_r[11] = s0; exp_r[12] = d; end p0 = 1'b0; end
        13: begin s1 = d; p1 = 1'b1; end
        14: begin if (p1) begin exp_r[13] = s1; exp_r[14] = d; end p1 = 1'b0; end
        default: if (k < NB) exp_r[k] = d;
      endcase
    end
  endtask

  task automatic do_write(input int n, input logic with_stop);
    logic ack;
    bus_start();
    send_byte(8'hD2, ack); chk("R1 write address ack", ack, 1);
    send_byte(8'($urandom), ack); chk("R2 command ack", ack, 1);
    send_byte(8'($urandom), ack); chk("R2 count ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      send_byte(wbuf[k], ack);
      if (k >= NB) chk("R12 overflow ack", ack, 1);
      else chk("R3 data ack", ack, 1);
    end
    if (with_stop) bus_stop();
    model_apply(n);
  endtask

  task automatic do_read(input int nb);
    logic ack;
    logic [7:0] d, e;
    bus_start();
    send_byte(8'hD3, ack); chk("R1 read address ack", ack, 1);
    recv_byte(1'b1, d); chk("R4 length byte", d, exp_r[8]);
    for (int k = 0; k < nb; k++) begin
      recv_byte(k < nb - 1, d);
      e = (k <= int'(exp_r[8]) && k < NB) ? exp_r[k] : 8'hFF;
      chk("R4 read data", d, e);
    end
    bus_stop();
  endtask

  task automatic cmp_regs(input string req);
    for (int k = 0; k < NB; k++) chk(req, regs[k*8 +: 8], exp_r[k]);
  endtask

  task automatic fill_rand(input int n);
    for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] s11, s12, s13, s14;
    void'($urandom(32'd4711));
    for (int k = 0; k < NB; k++) exp_r[k] = 8'h00;
    exp_r[7] = 8'hA5; exp_r[8] = 8'h08; exp_r[9] = 8'h10;
    w(10); rst_ni = 1'b1; w(10);

    // R10 reset state
    cmp_regs("R10 reset value");
    chk("R10 sda released", sda_oe, 0);

    // R1 foreign address
    bus_start();
    send_byte(8'hD4, ack); chk("R1 foreign address nack", ack, 0);
    send_byte(8'h00, ack); chk("R1 no ack after foreign", ack, 0);
    bus_stop();
    cmp_regs("R1 foreign no effect");

    // R2/R3 short write
    fill_rand(5);
    do_write(5, 1'b1);
    cmp_regs("R3 short write");

    // R5/R6 zero length, id write
    fill_rand(9); wbuf[8] = 8'h00; wbuf[7] = 8'h3C;
    do_write(9, 1'b1);
    chk("R5 zero becomes one", regs[8*8 +: 8], 8'h01);
    chk("R6 id fixed", regs[7*8 +: 8], 8'hA5);
    cmp_regs("R2 R3 prefix write");

    // R7 lone first byte of divider pair
    s11 = regs[11*8 +: 8]; s12 = regs[12*8 +: 8];
    fill_rand(12); wbuf[8] = 8'h05;
    do_write(12, 1'b1);
    chk("R7 lone byte11 dropped", regs[11*8 +: 8], s11);
    chk("R7 byte12 unchanged", regs[12*8 +: 8], s12);
    cmp_regs("R7 model");

    // R8 lone first byte of spread pair; divider pair commits
    s13 = regs[13*8 +: 8]; s14 = regs[14*8 +: 8];
    fill_rand(14); wbuf[8] = 8'h05;
    do_write(14, 1'b1);
    chk("R8 lone byte13 dropped", regs[13*8 +: 8], s13);
    chk("R8 byte14 unchanged", regs[14*8 +: 8], s14);
    chk("R7 pair commit lo", regs[11*8 +: 8], wbuf[11]);
    chk("R7 pair commit hi", regs[12*8 +: 8], wbuf[12]);

    // R9/R12 full write plus overflow
    fill_rand(23); wbuf[8] = 8'd20;
    do_write(23, 1'b1);
    chk("R9 byte19 stored", regs[19*8 +: 8], wbuf[19]);
    chk("R9 byte20 stored", regs[20*8 +: 8], wbuf[20]);
    chk("R8 pair commit lo", regs[13*8 +: 8], wbuf[13]);
    chk("R8 pair commit hi", regs[14*8 +: 8], wbuf[14]);
    cmp_regs("R12 overflow dropped");

    // R4 reads
    do_read(22);
    fill_rand(9); wbuf[8] = 8'd3;
    do_write(9, 1'b1);
    do_read(6);

    // R11 repeated start in the middle of a pair
    s11 = regs[11*8 +: 8]; s12 = regs[12*8 +: 8];
    fill_rand(12); wbuf[8] = 8'd2;
    do_write(12, 1'b0);
    do_read(3);
    chk("R11 restart drops pending lo", regs[11*8 +: 8], s11);
    chk("R11 restart drops pending hi", regs[12*8 +: 8], s12);
    cmp_regs("R11 restart model");

    // random transfers
    for (int it = 0; it < 4; it++) begin
      int n;
      n = int'($urandom_range(0, 23));
      fill_rand(24);
      do_write(n, 1'b1);
      cmp_regs("R3 random write");
      do_read(int'($urandom_range(1, 22)));
    end

    chk("R11 sda steady while scl high", viol, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule